// File: doc/BRIEF.md
# Two-Stage Keyed Watchdog Timer

This block is a watchdog that counts down in two stages. After it is enabled, a prescaled tick decrements a counter that starts at the first preload value. When the counter reaches zero on a tick, stage one has expired. The block can then pulse an interrupt, loads the second preload value, and counts again. When stage two expires in watchdog mode, the block sets a timeout flag. If reboot is enabled, it also raises a reset request that stays high until the system reset arrives. The timeout flag is kept through that system reset and is cleared only by power-on reset or by software, so boot code can see that a timeout happened.

Software works through a plain write/read strobe port. The two preload registers and the reload register are guarded by a key. Software first writes the byte 0x80 and then the byte 0x86 to the reload address, and the next write is then accepted. That one write, to any address, closes the key again. A reload write with bit 8 set restarts stage one and so prevents a timeout. A sticky lock bit in the control register forces the timer on and keeps it on until the next system reset.

Register addresses: 0 is stage-one preload, 1 is stage-two preload, 2 is reload/status, 3 is configuration, 4 is control, 5 is the countdown readback. Configuration bits: [1:0] select the interrupt type, [2] selects the fast tick, [5] enables reboot. Control bits: [0] is lock, [1] is enable, [2] selects free-running mode.

The key sequencer has three states:
- K_IDLE moves to K_HALF on a reload-address write whose low byte is 0x80.
- K_HALF moves to K_OPEN on a reload-address write whose low byte is 0x86. Any other write moves it back to K_IDLE.
- K_OPEN grants the next write and returns to K_IDLE.

The stage machine also has three states:
- S_OFF holds while the timer is disabled and moves to S_FIRST once the timer is enabled.
- S_FIRST moves to S_SECOND when stage one expires.
- S_SECOND moves to S_FIRST when stage two expires.
- A restart sends it to S_FIRST.
- A disable sends it to S_OFF.

Top module: `wdt2_top`

## Requirements
- R1: The key opens only after a reload-address (2) write with low byte 0x80 followed by a reload-address write with low byte 0x86. A write of any other kind between them, or the bytes in the wrong order, returns the sequencer to idle.
- R2: An open key grants exactly one write and then closes. Writes to addresses 0, 1 and 2 made without a granted key leave the registers unchanged.
- R3: A granted reload write with bit 8 set reloads the counter from the stage-one preload, enters stage one and clears the prescaler.
- R4: While enabled, the counter decrements once every 2^PRE_SHIFT clocks, or every 2^ALT_SHIFT clocks when config bit 2 is 1. While disabled, it holds the stage-one preload.
- R5: At a stage-one expiry the counter loads the stage-two preload. The irq output pulses for one clock unless config[1:0] is 2'b11.
- R6: At a stage-two expiry in watchdog mode (control bit 2 = 0), the timeout flag (read at bit 9 of address 2) is set. If config bit 5 is 1, rst_req rises and stays high until rst_n. The counter then reloads the stage-one preload.
- R7: In free-running mode (control bit 2 = 1), a stage-two expiry sets neither the flag nor rst_req.
- R8: Writing control bit 0 as 1 forces the enable on. After that, control writes are ignored until rst_n.
- R9: The timeout flag survives rst_n. It is cleared by por_n or by a granted reload write with bit 9 set.
- R10: Address 5 reads the live 20-bit count. After reset both preloads and the count are all ones, and config, control, irq and rst_req are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | System reset, active low; keeps the timeout flag |
| por_n | input | 1 | Power-on reset, active low; clears the timeout flag |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 32 | Combinational read data |
| irq | output | 1 | One-clock stage-one interrupt pulse |
| rst_req | output | 1 | Held reset request after a stage-two timeout |

## Verification
The hardest case to reach from the ports is a timeout that is followed by a system reset alone, with power-on reset not asserted. Only that situation shows that the flag outlives the reset it caused while every other register returns to its reset value. The stimulus keys in short preloads, lets both stages run out with reboot enabled, and pulses only rst_n. It then reads the flag before it clears it with a keyed write. Key sequences that are broken by a configuration write, or sent in the wrong order, are also driven, to show that a later protected write is dropped.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;

    typedef enum logic [2:0] {
        A_PRE1   = 3'd0,
        A_PRE2   = 3'd1,
        A_RELOAD = 3'd2,
        A_CFG    = 3'd3,
        A_CTRL   = 3'd4,
        A_COUNT  = 3'd5
    } wdt_addr_e;

    typedef enum logic [1:0] {
        K_IDLE = 2'd0,
        K_HALF = 2'd1,
        K_OPEN = 2'd2
    } key_state_e;

    typedef enum logic [1:0] {
        S_OFF    = 2'd0,
        S_FIRST  = 2'd1,
        S_SECOND = 2'd2
    } stage_e;

    localparam logic [7:0] KEY_FIRST  = 8'h80;
    localparam logic [7:0] KEY_SECOND = 8'h86;

    localparam int RELOAD_BIT = 8;
    localparam int FLAG_BIT   = 9;
    localparam int CFG_W      = 6;
    localparam int CFG_FAST   = 2;
    localparam int CFG_REBOOT = 5;
    localparam int CTRL_W     = 3;
    localparam int CTRL_LOCK  = 0;
    localparam int CTRL_EN    = 1;
    localparam int CTRL_FREE  = 2;

    localparam logic [1:0] IRQ_NONE = 2'b11;

endpackage

// File: rtl/wdt2_keyseq.sv
module wdt2_keyseq
    import wdt2_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_byte,
    output logic       grant
);

    key_state_e st, st_nx;
    logic       key_wr;

    assign key_wr = wr_en && (wr_addr == A_RELOAD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= K_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            K_IDLE: if (key_wr && wr_byte == KEY_FIRST) st_nx = K_HALF;
            K_HALF: if (wr_en) st_nx = (key_wr && wr_byte == KEY_SECOND) ? K_OPEN : K_IDLE;
            K_OPEN: if (wr_en) st_nx = K_IDLE;
            default: st_nx = K_IDLE;
        endcase
    end

    always_comb grant = (st == K_OPEN) && wr_en;

    assert_half_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == K_HALF && $past(st) != K_HALF) |-> $past(key_wr && wr_byte == KEY_FIRST));

    assert_open_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == K_OPEN && $past(st) != K_OPEN) |-> $past(st) == K_HALF);

    assert_single_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> st == K_IDLE);

endmodule

// File: rtl/wdt2_prescale.sv
module wdt2_prescale #(
    parameter int PRE_SHIFT = 15,
    parameter int ALT_SHIFT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic fast,
    output logic tick
);

    localparam logic [PRE_SHIFT-1:0] SLOW_TERM = '1;
    localparam logic [PRE_SHIFT-1:0] FAST_TERM = PRE_SHIFT'((1 << ALT_SHIFT) - 1);

    logic [PRE_SHIFT-1:0] pc;
    logic [PRE_SHIFT-1:0] term;

    assign term = fast ? FAST_TERM : SLOW_TERM;
    assign tick = run && !restart && (pc == term);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     pc <= '0;
        else if (!run || restart || tick) pc <= '0;
        else                            pc <= pc + 1'b1;
    end

    assert_tick_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    assert_idle_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> pc == '0);

endmodule

// File: rtl/wdt2_counter.sv
module wdt2_counter
    import wdt2_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic             tick,
    input  logic [CNT_W-1:0] pre1,
    input  logic [CNT_W-1:0] pre2,
    output logic [CNT_W-1:0] cnt,
    output logic             exp1,
    output logic             exp2
);

    stage_e           st, st_nx;
    logic [CNT_W-1:0] cnt_nx;
    logic             at_zero;

    assign at_zero = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= S_OFF;
            cnt <= '1;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        if (!run) begin
            st_nx  = S_OFF;
            cnt_nx = pre1;
        end else if (restart || st == S_OFF) begin
            st_nx  = S_FIRST;
            cnt_nx = pre1;
        end else if (tick) begin
            if (!at_zero) begin
                cnt_nx = cnt - 1'b1;
            end else begin
                unique case (st)
                    S_FIRST: begin
                        st_nx  = S_SECOND;
                        cnt_nx = pre2;
                    end
                    S_SECOND: begin
                        st_nx  = S_FIRST;
                        cnt_nx = pre1;
                    end
                    default: st_nx = S_OFF;
                endcase
            end
        end
    end

    always_comb begin
        exp1 = (st == S_FIRST)  && tick && at_zero;
        exp2 = (st == S_SECOND) && tick && at_zero;
    end

    assert_restart_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && restart) |=> (st == S_FIRST && cnt == $past(pre1)));

    assert_stage_swap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        exp1 |=> (st == S_SECOND && cnt == $past(pre2)));

    assert_hold_between_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && st != S_OFF && !tick && !restart) |=> $stable(cnt));

endmodule

// File: rtl/wdt2_top.sv
module wdt2_top
    import wdt2_pkg::*;
#(
    parameter int CNT_W     = 20,
    parameter int PRE_SHIFT = 15,
    parameter int ALT_SHIFT = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        por_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [2:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic        irq,
    output logic        rst_req
);

    logic              grant;
    logic [CNT_W-1:0]  pre1_q, pre2_q, cnt;
    logic [CFG_W-1:0]  cfg_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic              flag_q, irq_q, rst_q;
    logic              run, restart, flag_clr, tick, exp1, exp2;
    logic              timeout_wd;
    logic              unused_hi;

    assign unused_hi = ^wr_data;

    wdt2_keyseq u_key (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_byte (wr_data[7:0]),
        .grant   (grant)
    );

    assign run        = ctrl_q[CTRL_EN];
    assign restart    = grant && (wr_addr == A_RELOAD) && wr_data[RELOAD_BIT];
    assign flag_clr   = grant && (wr_addr == A_RELOAD) && wr_data[FLAG_BIT];
    assign timeout_wd = exp2 && !ctrl_q[CTRL_FREE];

    wdt2_prescale #(.PRE_SHIFT(PRE_SHIFT), .ALT_SHIFT(ALT_SHIFT)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (restart),
        .fast    (cfg_q[CFG_FAST]),
        .tick    (tick)
    );

    wdt2_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (restart),
        .tick    (tick),
        .pre1    (pre1_q),
        .pre2    (pre2_q),
        .cnt     (cnt),
        .exp1    (exp1),
        .exp2    (exp2)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre1_q <= '1;
            pre2_q <= '1;
            cfg_q  <= '0;
            ctrl_q <= '0;
        end else begin
            if (grant && wr_addr == A_PRE1) pre1_q <= wr_data[CNT_W-1:0];
            if (grant && wr_addr == A_PRE2) pre2_q <= wr_data[CNT_W-1:0];
            if (wr_en && wr_addr == A_CFG)  cfg_q  <= wr_data[CFG_W-1:0];
            if (wr_en && wr_addr == A_CTRL && !ctrl_q[CTRL_LOCK])
                ctrl_q <= {wr_data[CTRL_FREE], wr_data[CTRL_EN] | wr_data[CTRL_LOCK],
                           wr_data[CTRL_LOCK]};
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)          flag_q <= 1'b0;
        else if (timeout_wd) flag_q <= 1'b1;
        else if (flag_clr)   flag_q <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            rst_q <= 1'b0;
        end else begin
            irq_q <= exp1 && (cfg_q[1:0] != IRQ_NONE);
            rst_q <= rst_q || (timeout_wd && cfg_q[CFG_REBOOT]);
        end
    end

    always_comb begin
        irq     = irq_q;
        rst_req = rst_q;
        case (rd_addr)
            A_PRE1:   rd_data = 32'(pre1_q);
            A_PRE2:   rd_data = 32'(pre2_q);
            A_RELOAD: rd_data = 32'(flag_q) << FLAG_BIT;
            A_CFG:    rd_data = 32'(cfg_q);
            A_CTRL:   rd_data = 32'(ctrl_q);
            A_COUNT:  rd_data = 32'(cnt);
            default:  rd_data = '0;
        endcase
    end

    assert_unkeyed_pre1_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !grant && wr_addr == A_PRE1) |=> $stable(pre1_q));

    assert_rstreq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_q |=> rst_q);

    assert_flag_set_R6: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        timeout_wd |=> flag_q);

    assert_free_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (exp2 && ctrl_q[CTRL_FREE]) |=> rst_q == $past(rst_q));

    assert_lock_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[CTRL_LOCK] |=> (ctrl_q[CTRL_LOCK] && ctrl_q[CTRL_EN]));

    assert_flag_survives_R9: assert property (@(posedge clk) disable iff (!por_n)
        !rst_n |=> flag_q == $past(flag_q));

endmodule

// File: tb/sim_wdt2_top.sv
`timescale 1ns/1ps
module sim_wdt2_top;

    localparam int CW  = 20;
    localparam int PRE = 4;
    localparam int ALT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        por_n = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq, rst_req;

    int checks = 0;
    int fails  = 0;
    int irq_seen = 0;
    bit cmp_on = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    wdt2_top #(.CNT_W(CW), .PRE_SHIFT(PRE), .ALT_SHIFT(ALT)) u0 (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .rst_req(rst_req)
    );

    // Behavioural reference model
    int          m_key = 0, m_st = 0, m_pc = 0;
    logic [CW-1:0] m_cnt = '1, m_p1 = '1, m_p2 = '1;
    logic [5:0]  m_cfg = '0;
    logic [2:0]  m_ctrl = '0;
    bit          m_flag = 0, m_irq = 0, m_rst = 0;

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return 32'(m_p1);
            3'd1: return 32'(m_p2);
            3'd2: return 32'(m_flag) << 9;
            3'd3: return 32'(m_cfg);
            3'd4: return 32'(m_ctrl);
            3'd5: return 32'(m_cnt);
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n or negedge por_n) begin
        if (!rst_n) begin
            if (!por_n) m_flag = 0;
            m_key = 0; m_st = 0; m_pc = 0;
            m_cnt = '1; m_p1 = '1; m_p2 = '1; m_cfg = '0; m_ctrl = '0;
            m_irq = 0; m_rst = 0;
        end else begin
            int  nk, n;
            bit  g, rs, fc, tk, e1, e2, run;
            nk = m_key; g = 0; e1 = 0; e2 = 0;
            run = m_ctrl[1];
            n = m_cfg[2] ? (1 << ALT) : (1 << PRE);
            if (wr_en) begin
                if (m_key == 0) begin
                    if (wr_addr == 3'd2 && wr_data[7:0] == 8'h80) nk = 1;
                end else if (m_key == 1) begin
                    nk = (wr_addr == 3'd2 && wr_data[7:0] == 8'h86) ? 2 : 0;
                end else begin
                    nk = 0; g = 1;
                end
            end
            rs = g && wr_addr == 3'd2 && wr_data[8];
            fc = g && wr_addr == 3'd2 && wr_data[9];
            tk = run && !rs && (m_pc == n - 1);
            if (!run || rs || tk) m_pc = 0;
            else m_pc = (m_pc + 1) % (1 << PRE);
            if (!run) begin
                m_st = 0; m_cnt = m_p1;
            end else if (rs || m_st == 0) begin
                m_st = 1; m_cnt = m_p1;
            end else if (tk) begin
                if (m_cnt != 0) m_cnt = m_cnt - 1;
                else if (m_st == 1) begin e1 = 1; m_st = 2; m_cnt = m_p2; end
                else begin e2 = 1; m_st = 1; m_cnt = m_p1; end
            end
            m_irq = e1 && (m_cfg[1:0] != 2'b11);
            if (e2 && !m_ctrl[2] && m_cfg[5]) m_rst = 1;
            if (e2 && !m_ctrl[2]) m_flag = 1;
            else if (fc) m_flag = 0;
            if (g && wr_addr == 3'd0) m_p1 = wr_data[CW-1:0];
            if (g && wr_addr == 3'd1) m_p2 = wr_data[CW-1:0];
            if (wr_en && wr_addr == 3'd3) m_cfg = wr_data[5:0];
            if (wr_en && wr_addr == 3'd4 && !m_ctrl[0])
                m_ctrl = {wr_data[2], wr_data[1] | wr_data[0], wr_data[0]};
            m_key = nk;
        end
    end

    // Per-cycle comparison, sampled after the edge
    always @(posedge clk) begin
        #1;
        if (irq) irq_seen++;
        if (cmp_on && !done) begin
            checks += 3;
            if (irq !== m_irq) begin
                fails++;
                $display("FAIL R5 irq act %0b exp %0b at %0t", irq, m_irq, $time);
            end
            if (rst_req !== m_rst) begin
                fails++;
                $display("FAIL R6 rst_req act %0b exp %0b at %0t", rst_req, m_rst, $time);
            end
            if (rd_data !== m_read(rd_addr)) begin
                fails++;
                $display("FAIL R10 rd[%0d] act %h exp %h at %0t", rd_addr, rd_data,
                         m_read(rd_addr), $time);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act %h exp %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic key();
        wr(3'd2, 32'h80);
        wr(3'd2, 32'h86);
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    task automatic sys_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        #1; rst_n = 1'b0; por_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; por_n = 1'b1;
        cmp_on = 1;

        // R10 reset state
        rd(3'd0, v); chk("R10 pre1 reset", v, 32'hFFFFF);
        rd(3'd5, v); chk("R10 count reset", v, 32'hFFFFF);
        rd(3'd2, v); chk("R10 flag reset", v, 32'h0);
        chk("R10 irq reset", {31'd0, irq}, 32'd0);
        chk("R10 rst_req reset", {31'd0, rst_req}, 32'd0);

        // R2 unkeyed write ignored
        wr(3'd0, 32'd5);
        rd(3'd0, v); chk("R2 unkeyed pre1", v, 32'hFFFFF);

        // R1/R2 keyed write, then single grant
        key(); wr(3'd0, 32'd5);
        rd(3'd0, v); chk("R1 keyed pre1", v, 32'd5);
        wr(3'd0, 32'd7);
        rd(3'd0, v); chk("R2 second write dropped", v, 32'd5);

        // R1 wrong order
        wr(3'd2, 32'h86); wr(3'd2, 32'h80); wr(3'd1, 32'd9);
        rd(3'd1, v); chk("R1 wrong order", v, 32'hFFFFF);

        // R1 interrupted sequence
        wr(3'd2, 32'h80); wr(3'd3, 32'h20); wr(3'd2, 32'h86); wr(3'd1, 32'd3);
        rd(3'd1, v); chk("R1 interrupted", v, 32'hFFFFF);
        rd(3'd3, v); chk("R1 cfg write applied", v, 32'h20);

        key(); wr(3'd1, 32'd3);
        rd(3'd1, v); chk("R2 pre2 keyed", v, 32'd3);

        // Enable watchdog, slow tick
        irq_seen = 0;
        wr(3'd4, 32'h2);
        rd(3'd5, v); chk("R4 count starts at pre1", v, 32'd5);
        repeat (40) @(negedge clk);
        key(); wr(3'd2, 32'h100);
        rd(3'd5, v); chk("R3 reload restarts", v, 32'd5);
        chk("R3 no irq before expiry", irq_seen, 0);

        repeat (200) @(negedge clk);
        chk("R5 one stage-one irq", irq_seen, 1);
        chk("R6 rst_req raised", {31'd0, rst_req}, 32'd1);
        rd(3'd2, v); chk("R6 flag set", v, 32'h200);

        // R9 flag survives system reset
        sys_reset();
        chk("R6 rst_req cleared by rst_n", {31'd0, rst_req}, 32'd0);
        rd(3'd2, v); chk("R9 flag survives rst_n", v, 32'h200);
        rd(3'd0, v); chk("R9 pre1 back to reset", v, 32'hFFFFF);
        key(); wr(3'd2, 32'h200);
        rd(3'd2, v); chk("R9 flag cleared", v, 32'h0);

        // R7 free-running, irq type none
        key(); wr(3'd0, 32'd2);
        key(); wr(3'd1, 32'd1);
        wr(3'd3, 32'h23);
        irq_seen = 0;
        wr(3'd4, 32'h6);
        repeat (400) @(negedge clk);
        chk("R7 free no rst_req", {31'd0, rst_req}, 32'd0);
        rd(3'd2, v); chk("R7 free no flag", v, 32'h0);
        chk("R5 type none no irq", irq_seen, 0);

        // R4 disabled holds pre1; fast tick
        wr(3'd4, 32'h0);
        rd(3'd5, v); chk("R4 disabled holds pre1", v, 32'd2);
        wr(3'd3, 32'h24);
        wr(3'd4, 32'h2);
        repeat (40) @(negedge clk);
        chk("R4 fast tick timeout", {31'd0, rst_req}, 32'd1);

        // R8 lock
        sys_reset();
        wr(3'd4, 32'h1);
        rd(3'd4, v); chk("R8 lock forces enable", v, 32'h3);
        wr(3'd4, 32'h0);
        rd(3'd4, v); chk("R8 disable ignored", v, 32'h3);
        repeat (60) @(negedge clk);
        sys_reset();
        rd(3'd4, v); chk("R8 rst_n clears lock", v, 32'h0);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule